// File: doc/BRIEF.md
# NAND Boot Pointer Scanner

This block searches the start of a NAND array for the page number of a boot image. After a start pulse it walks the pages upward from page 0. Each byte comes through a simple read port: the block names a page and a column and waits for the response. From each page it fetches a three-byte pointer field that sits at a fixed column. Every page except page 0 must also carry a three-byte signature at columns 0 to 2 before its pointer is trusted.

The scan ends on the first page whose pointer is trusted, is non-zero and does not name the page it sits on. The block then raises `done` and holds the pointer on `boot_ptr`. If no page qualifies within the scanned range, it raises `done` together with `not_found`, and `boot_ptr` reads zero. Command and address cycles, error correction and device identification are assumed to sit behind the read port.

Top module: `bps_scanner`

## Requirements
- R1: After reset, `busy`, `done`, `not_found` and `rd_req` are 0 and `boot_ptr` is 0.
- R2: Once `rd_req` is raised, it stays high with `rd_page` and `rd_col` unchanged until the cycle in which `rd_ack` is high. `rd_data` is taken in that same cycle, and each acknowledge consumes exactly one byte.
- R3: Pages are visited in ascending order starting at page 0. No page is skipped and none is revisited, and no page at or above NUM_PAGES (default 256) is requested.
- R4: On page 0 only the pointer columns 0xC4, 0xC5 and 0xC6 are read, in that order. The pointer is used there without any signature.
- R5: On every page above 0, columns 0, 1 and 2 are read first and must hold 0xE9, 0x00 and 0x00. At the first byte that differs, the page is abandoned: no further column of it is read, and the scan moves to the next page.
- R6: The pointer is the 24-bit little-endian value of columns 0xC4 (bits 7:0), 0xC5 (bits 15:8) and 0xC6 (bits 23:16).
- R7: A pointer of zero is not accepted, and the scan continues with the next page.
- R8: A pointer equal to the number of the page that holds it (compared over all 24 bits) is rejected, and the scan continues.
- R9: On acceptance, `done` rises, `not_found` stays 0 and `boot_ptr` carries the pointer. `busy` and `rd_req` are 0 and these outputs hold until the next start.
- R10: If the last page is passed without acceptance, `done` and `not_found` are both 1 and `boot_ptr` is 0.
- R11: `start` begins a new scan while idle or finished. A `start` pulse during a scan has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (one-cycle pulse) |
| rd_req | output | 1 | Byte read request |
| rd_page | output | PAGE_W (8) | Page number of the request |
| rd_col | output | COL_W (8) | Column of the request |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished |
| not_found | output | 1 | Finished without an acceptable pointer |
| boot_ptr | output | PTR_W (24) | Accepted pointer, zero if none |

## Verification
Two actions can fall on the same acknowledge: a signature byte that fails to match, and leaving the last page. When both happen, the abandoned page and the end of the array must resolve to `not_found` at once, rather than to a request for page 256. The bench provokes this with an array that is entirely blank and with a last page whose signature is broken. It judges the result by the `done`/`not_found` pair, the zero pointer and the exact read count of 258. A start pulse during the blank scan checks that the count is not disturbed.

// File: rtl/bps_pkg.sv
package bps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_EVAL,
      ST_DONE
   } scan_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/bps_addr_gen.sv
module bps_addr_gen #(
   parameter int NUM_PAGES = 256,
   parameter int PAGE_W    = 8,
   parameter int COL_W     = 8,
   parameter int PTR_COL   = 'hC4,
   parameter int SIG_N     = 3,
   parameter int STEP_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step_byte,
   input  logic              next_page,
   output logic [PAGE_W-1:0] page,
   output logic [STEP_W-1:0] step,
   output logic [COL_W-1:0]  col,
   output logic              last_page
);
   localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(NUM_PAGES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page <= '0;
         step <= '0;
      end else if (clr) begin
         page <= '0;
         step <= STEP_W'(SIG_N);
      end else if (next_page) begin
         page <= page + 1'b1;
         step <= '0;
      end else if (step_byte) begin
         step <= step + 1'b1;
      end
   end

   always_comb begin
      if (step < STEP_W'(SIG_N)) col = COL_W'(step);
      else                       col = COL_W'(PTR_COL) + COL_W'(step - STEP_W'(SIG_N));
   end

   assign last_page = (page == LAST_PG);
endmodule

// File: rtl/bps_sig_check.sv
module bps_sig_check #(
   parameter int          SIG_N    = 3,
   parameter int          STEP_W   = 3,
   parameter logic [23:0] SIG_WORD = 24'h0000E9
) (
   input  logic [STEP_W-1:0] step,
   input  logic [7:0]        data,
   output logic              match
);
   logic [SIG_N-1:0] hit;

   for (genvar g = 0; g < SIG_N; g++) begin : g_hit
      assign hit[g] = (data == SIG_WORD[8*g +: 8]);
   end

   always_comb begin
      match = 1'b0;
      for (int i = 0; i < SIG_N; i++) begin
         if (step == STEP_W'(i)) match = hit[i];
      end
   end
endmodule

// File: rtl/bps_ptr_asm.sv
module bps_ptr_asm #(
   parameter int PTR_BYTES = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   load,
   input  logic [7:0]             data,
   output logic [8*PTR_BYTES-1:0] ptr
);
   logic [7:0] lane [PTR_BYTES];

   for (genvar g = 0; g < PTR_BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     lane[g] <= '0;
         else if (clr)   lane[g] <= '0;
         else if (load) begin
            if (g == PTR_BYTES - 1) lane[g] <= data;
            else                    lane[g] <= lane[(g + 1) % PTR_BYTES];
         end
      end
      assign ptr[8*g +: 8] = lane[g];
   end
endmodule

// File: rtl/bps_scanner.sv
module bps_scanner
   import bps_pkg::*;
#(
   parameter int          NUM_PAGES = 256,
   parameter int          PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
   parameter int          COL_W     = 8,
   parameter int          PTR_COL   = 'hC4,
   parameter int          PTR_BYTES = 3,
   parameter int          PTR_W     = 8 * PTR_BYTES,
   parameter int          SIG_N     = 3,
   parameter logic [23:0] SIG_WORD  = 24'h0000E9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [PAGE_W-1:0] rd_page,
   output logic [COL_W-1:0]  rd_col,
   input  logic              rd_ack,
   input  logic [7:0]        rd_data,
   output logic              busy,
   output logic              done,
   output logic              not_found,
   output logic [PTR_W-1:0]  boot_ptr
);
   localparam int STEP_W    = $clog2(SIG_N + PTR_BYTES + 1);
   localparam int LAST_STEP = SIG_N + PTR_BYTES - 1;

   if (NUM_PAGES < 2) begin : g_bad_pages
      $error("bps_scanner: NUM_PAGES must be at least 2");
   end
   if (PAGE_W > PTR_W || (1 << PAGE_W) < NUM_PAGES) begin : g_bad_pw
      $error("bps_scanner: PAGE_W does not fit NUM_PAGES or PTR_W");
   end
   if (PTR_COL + PTR_BYTES > (1 << COL_W) || PTR_COL < SIG_N) begin : g_bad_col
      $error("bps_scanner: pointer columns out of range");
   end
   if (PTR_W != 8 * PTR_BYTES || SIG_N > 3) begin : g_bad_w
      $error("bps_scanner: width parameters inconsistent");
   end

   scan_state_e       state, state_nx;
   logic [PAGE_W-1:0] page;
   logic [STEP_W-1:0] step;
   logic              last_page, sig_ok;
   logic [PTR_W-1:0]  ptr_val;
   logic              addr_clr, step_byte, next_page, ptr_clr, ptr_load;
   logic              fin_found, fin_none;
   logic              in_sig, ptr_good;

   bps_addr_gen #(
      .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W), .COL_W(COL_W),
      .PTR_COL(PTR_COL), .SIG_N(SIG_N), .STEP_W(STEP_W)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(addr_clr), .step_byte(step_byte),
      .next_page(next_page), .page(page), .step(step), .col(rd_col),
      .last_page(last_page)
   );

   bps_sig_check #(.SIG_N(SIG_N), .STEP_W(STEP_W), .SIG_WORD(SIG_WORD)) u_sig (
      .step(step), .data(rd_data), .match(sig_ok)
   );

   bps_ptr_asm #(.PTR_BYTES(PTR_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .load(ptr_load),
      .data(rd_data), .ptr(ptr_val)
   );

   assign in_sig   = (step < STEP_W'(SIG_N));
   assign ptr_good = (ptr_val != '0) && (ptr_val != PTR_W'(page));

   always_comb begin
      state_nx  = state;
      addr_clr  = 1'b0;
      step_byte = 1'b0;
      next_page = 1'b0;
      ptr_clr   = 1'b0;
      ptr_load  = 1'b0;
      fin_found = 1'b0;
      fin_none  = 1'b0;
      unique case (state)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               addr_clr = 1'b1;
               ptr_clr  = 1'b1;
               state_nx = ST_RD;
            end
         end
         ST_RD: begin
            if (rd_ack) begin
               if (in_sig) begin
                  if (!sig_ok) begin
                     if (last_page) begin
                        fin_none = 1'b1;
                        state_nx = ST_DONE;
                     end else begin
                        next_page = 1'b1;
                     end
                  end else begin
                     step_byte = 1'b1;
                  end
               end else begin
                  ptr_load = 1'b1;
                  if (step == STEP_W'(LAST_STEP)) state_nx = ST_EVAL;
                  else                            step_byte = 1'b1;
               end
            end
         end
         ST_EVAL: begin
            if (ptr_good) begin
               fin_found = 1'b1;
               state_nx  = ST_DONE;
            end else if (last_page) begin
               fin_none = 1'b1;
               state_nx = ST_DONE;
            end else begin
               next_page = 1'b1;
               state_nx  = ST_RD;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         done      <= 1'b0;
         not_found <= 1'b0;
         boot_ptr  <= '0;
      end else begin
         state <= state_nx;
         if (addr_clr) begin
            done      <= 1'b0;
            not_found <= 1'b0;
            boot_ptr  <= '0;
         end else if (fin_found) begin
            done     <= 1'b1;
            boot_ptr <= ptr_val;
         end else if (fin_none) begin
            done      <= 1'b1;
            not_found <= 1'b1;
         end
      end
   end

   assign rd_req  = (state == ST_RD);
   assign rd_page = page;
   assign busy    = (state == ST_RD) || (state == ST_EVAL);
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
   parameter int PAGE_W    = 8,
   parameter int COL_W     = 8,
   parameter int PTR_W     = 24,
   parameter int PTR_COL   = 'hC4,
   parameter int PTR_BYTES = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic [PAGE_W-1:0] rd_page,
   input logic [COL_W-1:0]  rd_col,
   input logic              rd_ack,
   input logic              busy,
   input logic              done,
   input logic              not_found,
   input logic [PTR_W-1:0]  boot_ptr
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req && $stable(rd_page) && $stable(rd_col)); // R2

   AST_PAGE0_COLS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_page == '0 |->
         rd_col >= COL_W'(PTR_COL) && rd_col < COL_W'(PTR_COL + PTR_BYTES)); // R4

   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_ack |=> rd_page == $past(rd_page) || rd_page == $past(rd_page) + 1'b1
                           || done); // R3

   AST_FOUND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done && !not_found |-> boot_ptr != '0 && boot_ptr != PTR_W'(rd_page)); // R8

   AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      not_found |-> done && boot_ptr == '0); // R10

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !rd_req); // R9
endmodule

bind bps_scanner bps_checker #(
   .PAGE_W(PAGE_W), .COL_W(COL_W), .PTR_W(PTR_W),
   .PTR_COL(PTR_COL), .PTR_BYTES(PTR_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_page(rd_page),
   .rd_col(rd_col), .rd_ack(rd_ack), .busy(busy), .done(done),
   .not_found(not_found), .boot_ptr(boot_ptr)
);

// File: tb/tb_bps_scanner.sv
module tb_bps_scanner;
   localparam int CLK_PERIOD = 10;
   localparam int WAIT_LIMIT = 20000;

   typedef struct packed {
      logic [23:0] p0val;
      logic [7:0]  pg;
      logic        sig;
      logic [23:0] val;
      logic [7:0]  decoy;
      logic        exp_nf;
      logic [23:0] exp_ptr;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{24'h030201, 8'd0,   1'b0, 24'h0,      8'd0, 1'b0, 24'h030201}, // R4 R6
      '{24'h0,      8'd5,   1'b1, 24'h0A0B0C, 8'd0, 1'b0, 24'h0A0B0C}, // R5 R6
      '{24'h0,      8'd5,   1'b0, 24'h000010, 8'd0, 1'b1, 24'h0},      // R5 R10
      '{24'h0,      8'd9,   1'b1, 24'h123456, 8'd3, 1'b0, 24'h123456}, // R5
      '{24'h0,      8'd7,   1'b1, 24'h000007, 8'd0, 1'b1, 24'h0},      // R8
      '{24'h0,      8'd7,   1'b1, 24'h000107, 8'd0, 1'b0, 24'h000107}, // R8
      '{24'h0,      8'd255, 1'b1, 24'h00ABCD, 8'd0, 1'b0, 24'h00ABCD}, // R3
      '{24'h000005, 8'd2,   1'b1, 24'h000099, 8'd0, 1'b0, 24'h000005}, // R3
      '{24'h0,      8'd4,   1'b1, 24'h0,      8'd0, 1'b1, 24'h0}       // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_req;
   logic [7:0]  rd_page;
   logic [7:0]  rd_col;
   logic        rd_ack = 1'b0;
   logic [7:0]  rd_data = 8'h00;
   logic        busy, done, not_found;
   logic [23:0] boot_ptr;

   int   checks = 0;
   int   errors = 0;
   vec_t cur;
   int   nreads;
   int   viol;
   int   prev_page;
   int   first_col;
   int   wait_cnt;

   bps_scanner dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
      .rd_page(rd_page), .rd_col(rd_col), .rd_ack(rd_ack), .rd_data(rd_data),
      .busy(busy), .done(done), .not_found(not_found), .boot_ptr(boot_ptr)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [7:0] nand_byte(input int page, input int col);
      if (page == 0) begin
         if (col >= 'hC4 && col <= 'hC6) return cur.p0val[8*(col - 'hC4) +: 8];
         return 8'hFF;
      end
      if (page == int'(cur.pg)) begin
         if (col == 0) return 8'hE9;
         if (col == 1) return 8'h00;
         if (col == 2) return cur.sig ? 8'h00 : 8'h01;
         if (col >= 'hC4 && col <= 'hC6) return cur.val[8*(col - 'hC4) +: 8];
         return 8'hFF;
      end
      if (cur.decoy != 0 && page == int'(cur.decoy)) begin
         if (col == 0) return 8'hE9;
         if (col == 1) return 8'h01;
         if (col == 2) return 8'h00;
         return 8'h77;
      end
      return 8'hFF;
   endfunction

   // Array model: varying latency, one-cycle acknowledge, order tracking
   initial begin
      int lat;
      lat = 0;
      forever begin
         @(negedge clk);
         if (rd_ack) begin
            rd_ack = 1'b0;
         end else if (rd_req) begin
            if (lat >= nreads % 3) begin
               lat = 0;
               if (nreads == 0) first_col = int'(rd_col);
               if (int'(rd_page) < prev_page || int'(rd_page) > prev_page + 1) viol++;
               if (rd_page == 8'd0 && (rd_col < 8'hC4 || rd_col > 8'hC6)) viol++;
               prev_page = int'(rd_page);
               rd_data = nand_byte(int'(rd_page), int'(rd_col));
               rd_ack  = 1'b1;
               nreads++;
            end else begin
               lat++;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic launch();
      nreads    = 0;
      viol      = 0;
      prev_page = 0;
      first_col = -1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      wait_cnt = 0;
      while (!done && wait_cnt < WAIT_LIMIT) begin
         @(negedge clk);
         wait_cnt++;
      end
      check(done == 1'b1, "R9", "watchdog: done", int'(done), 1);
   endtask

   initial begin
      nreads = 0; viol = 0; prev_page = 0; first_col = -1;
      cur = VECS[0];
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && !not_found && !rd_req, "R1", "flags after reset",
            {busy, done, not_found, rd_req}, 0);
      check(boot_ptr == 24'h0, "R1", "pointer after reset", int'(boot_ptr), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !rd_req, "R1", "idle without start", {busy, rd_req}, 0);

      // Vector walk
      for (int i = 0; i < NV; i++) begin
         cur = VECS[i];
         launch();
         wait_done();
         repeat (2) @(negedge clk);
         check(not_found == cur.exp_nf, "R9 R10", $sformatf("vec %0d not_found", i),
               int'(not_found), int'(cur.exp_nf));
         check(boot_ptr == cur.exp_ptr, "R6 R8", $sformatf("vec %0d pointer", i),
               int'(boot_ptr), int'(cur.exp_ptr));
         check(viol == 0, "R3 R4", $sformatf("vec %0d read order", i), viol, 0);
         check(done && !busy && !rd_req, "R9", $sformatf("vec %0d held", i),
               {done, busy, rd_req}, 3'b100);
         if (i == 0) begin
            check(first_col == 'hC4, "R4", "first column on page 0", first_col, 'hC4);
            check(nreads == 3, "R4", "reads for page-0 pointer", nreads, 3);
         end
         if (i == 1) begin
            // page 0: 3, pages 1..4 blank abort at byte 0: 4, page 5: 6
            check(nreads == 13, "R5", "reads up to signed page", nreads, 13);
         end
      end

      // R5 R10: blank array, last page abandoned on first byte; start mid-scan (R11)
      cur = '{24'h0, 8'd0, 1'b0, 24'h0, 8'd0, 1'b1, 24'h0};
      launch();
      repeat (100) @(negedge clk);
      check(busy == 1'b1, "R11", "busy mid-scan", int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      @(negedge clk);
      check(nreads == 258, "R5 R11", "reads on blank array", nreads, 258);
      check(not_found && boot_ptr == 24'h0, "R10", "blank array result",
            {not_found, boot_ptr}, {1'b1, 24'h0});
      check(viol == 0, "R3", "blank array order", viol, 0);

      // R11: restart from finished state clears the result
      cur = VECS[1];
      launch();
      check(!done && !not_found && boot_ptr == 24'h0, "R11", "restart clears",
            {done, not_found, boot_ptr}, 0);
      wait_done();
      @(negedge clk);
      check(boot_ptr == 24'h0A0B0C, "R11", "restart result", int'(boot_ptr), 'h0A0B0C);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule